// File: doc/BRIEF.md
# Burst-Limited Multi-Channel Bus Arbiter

This block schedules access to a single memory-bus master port shared by several virtual channels of a network interface. Each channel is armed with a word count through a start pulse. From then on it competes for the bus until every one of those words has been acknowledged. Only one channel owns the port at any time. The owner keeps it until one of three events: it finishes its transfer, it completes a burst of the configured maximum length, or its internal FIFO reports full.

Every loss of ownership is followed by exactly one cycle with no bus request. After that cycle a round-robin choice hands the port to the next eligible channel. The choice starts just past the channel that last owned the port. A lone active channel is simply granted again. When a channel moves its final word, it emits a one-cycle done pulse and goes inactive. Bursts and re-arbitration continue until all armed channels have drained.

Top module: `vc_burst_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every grant, the bus request, all done pulses, all active flags and all remaining counts, and places the round-robin pointer on channel 0. With several channels armed together after reset, channel 0 is served first.
- R2: A start pulse on an inactive channel with a nonzero length loads that length into the channel's remaining count and sets it active on the next edge. A start pulse on an active channel, or one with length zero, changes nothing. The longest length is 2^XFER_W words.
- R3: A word counts, and the owner's remaining count drops by one, only on an edge where that channel holds the grant and the bus acknowledge is high.
- R4: After MAX_BURST counted words within one ownership, the grant is withdrawn on the same edge that counts the last word.
- R5: If the owning channel's FIFO-full input is high in a cycle, the grant is withdrawn on the following edge, even in the middle of a burst.
- R6: After every withdrawal, the bus request stays low for exactly one cycle before any new grant is issued, as long as a channel is eligible.
- R7: A new grant goes to the first eligible channel, searching upward with wraparound from the channel after the last owner. A single eligible channel is granted again.
- R8: When the last word of a transfer is counted, done for that channel is high for exactly the next cycle, its active flag clears, and the grant is withdrawn.
- R9: A channel whose FIFO-full input is high during the arbitration cycle is not chosen.
- R10: At most one grant bit is high, the bus request is high exactly when a grant is held, and only active channels hold a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | NUM_CH | Per-channel pulse that arms a new transfer |
| len_i | input | NUM_CH*(XFER_W+1) | Per-channel word count, channel c in bits c*(XFER_W+1) upward |
| fifo_full_i | input | NUM_CH | Per-channel internal FIFO full |
| bus_ack_i | input | 1 | Bus acknowledge for the current word |
| bus_req_o | output | 1 | Bus request, registered |
| grant_o | output | NUM_CH | One-hot owner of the bus, registered |
| done_o | output | NUM_CH | One-cycle pulse when a channel's transfer ends |
| active_o | output | NUM_CH | Channel armed and not yet drained |
| remaining_o | output | NUM_CH*(XFER_W+1) | Words still to move per channel, same packing as len_i |

## Verification
The arbiter is driven with a lone channel whose length is not a multiple of the burst size. This separates burst cuts from end-of-transfer cuts and shows the re-grant to the same channel. Three channels armed together with unequal lengths expose the rotation order. A stalling, random acknowledge shows that only acknowledged words advance counters. Random FIFO-full pulses separate the mid-burst cut from the arbitration skip. Ignored starts, unit-length transfers and a maximum-length transfer cover the count-loading boundaries.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  // index width that stays at least one bit for a single channel
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vcb_rr_pick.sv
module vcb_rr_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  elig_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    int pos;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      pos = int'(ptr_i) + k;
      if (pos >= N) pos = pos - N;
      if (!found_o && elig_i[pos]) begin
        found_o = 1'b1;
        idx_o   = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/vcb_chan_state.sv
module vcb_chan_state #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  input  logic          take_i,
  output logic          active_o,
  output logic [CW-1:0] rem_o,
  output logic          last_o,
  output logic          done_o
);
  assign last_o = (rem_o == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      rem_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take_i && active_o) begin
        rem_o <= rem_o - CW'(1);
        if (last_o) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end
      end
      if (start_i && !active_o && (len_i != '0)) begin
        active_o <= 1'b1;
        rem_o    <= len_i;
      end
    end
  end

  p_active_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (rem_o != '0));
  p_take_needs_active_r3: assert property (@(posedge clk) disable iff (rst)
    take_i |-> active_o);
  p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!active_o && $past(take_i)));
endmodule

// File: rtl/vc_burst_arbiter.sv
module vc_burst_arbiter #(
  parameter int NUM_CH    = 2,
  parameter int MAX_BURST = 16,
  parameter int XFER_W    = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          start_i,
  input  logic [NUM_CH*(XFER_W+1)-1:0] len_i,
  input  logic [NUM_CH-1:0]          fifo_full_i,
  input  logic                       bus_ack_i,
  output logic                       bus_req_o,
  output logic [NUM_CH-1:0]          grant_o,
  output logic [NUM_CH-1:0]          done_o,
  output logic [NUM_CH-1:0]          active_o,
  output logic [NUM_CH*(XFER_W+1)-1:0] remaining_o
);
  localparam int CNT_W = XFER_W + 1;
  localparam int IDX_W = vcb_pkg::idx_width(NUM_CH);
  localparam int BC_W  = $clog2(MAX_BURST) + 1;

  logic [NUM_CH-1:0] grant_q, take_w, last_w, elig_w;
  logic              req_q;
  logic [BC_W-1:0]   bc_q;
  logic [IDX_W-1:0]  ptr_q, cur_idx, ptr_after, pick_idx;
  logic              pick_valid, xfer, hit_max, cur_full, cur_last, cut;

  assign take_w = grant_q & {NUM_CH{bus_ack_i}};
  assign elig_w = active_o & ~fifo_full_i;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      vcb_chan_state #(.CW(CNT_W)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i[c]),
        .len_i    (len_i[c*CNT_W +: CNT_W]),
        .take_i   (take_w[c]),
        .active_o (active_o[c]),
        .rem_o    (remaining_o[c*CNT_W +: CNT_W]),
        .last_o   (last_w[c]),
        .done_o   (done_o[c])
      );
    end
  endgenerate

  vcb_rr_pick #(.N(NUM_CH), .IW(IDX_W)) u_pick (
    .elig_i  (elig_w),
    .ptr_i   (ptr_q),
    .found_o (pick_valid),
    .idx_o   (pick_idx)
  );

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (grant_q[i]) cur_idx = IDX_W'(i);
  end

  assign cur_full  = fifo_full_i[cur_idx];
  assign cur_last  = last_w[cur_idx];
  assign xfer      = req_q && bus_ack_i;
  assign hit_max   = xfer && (bc_q == BC_W'(MAX_BURST - 1));
  assign cut       = req_q && ((xfer && cur_last) || hit_max || cur_full);
  assign ptr_after = (cur_idx == IDX_W'(NUM_CH - 1)) ? '0 : cur_idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      req_q   <= 1'b0;
      bc_q    <= '0;
      ptr_q   <= '0;
    end else if (req_q) begin
      if (cut) begin
        grant_q <= '0;
        req_q   <= 1'b0;
        bc_q    <= '0;
        ptr_q   <= ptr_after;
      end else if (xfer) begin
        bc_q <= bc_q + BC_W'(1);
      end
    end else if (pick_valid) begin
      grant_q <= NUM_CH'(1) << pick_idx;
      req_q   <= 1'b1;
    end
  end

  assign grant_o   = grant_q;
  assign bus_req_o = req_q;

  p_burst_limit_r4: assert property (@(posedge clk) disable iff (rst)
    bc_q < BC_W'(MAX_BURST));
  p_full_cut_r5: assert property (@(posedge clk) disable iff (rst)
    (req_q && ((grant_q & fifo_full_i) != '0)) |=> !req_q);
  p_no_direct_switch_r6: assert property (@(posedge clk) disable iff (rst)
    req_q |=> (!req_q || $stable(grant_q)));
  p_pick_not_full_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> ((grant_q & $past(fifo_full_i)) == '0));
  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q) && ((grant_q & ~active_o) == '0));
endmodule

// File: tb/vc_burst_arbiter_tb.sv
`timescale 1ns/1ps
module vc_burst_arbiter_tb;
  localparam int N  = 3;
  localparam int MB = 4;
  localparam int XW = 13;
  localparam int CW = XW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] start = '0, full = '0;
  logic [N*CW-1:0] len = '0;
  logic ack = 1'b0;
  logic bus_req;
  logic [N-1:0] grant, done, active;
  logic [N*CW-1:0] remaining;

  always #2 clk = ~clk;

  vc_burst_arbiter #(.NUM_CH(N), .MAX_BURST(MB), .XFER_W(XW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .len_i(len), .fifo_full_i(full),
    .bus_ack_i(ack), .bus_req_o(bus_req), .grant_o(grant), .done_o(done),
    .active_o(active), .remaining_o(remaining)
  );

  int n_cmp = 0, n_bad = 0;
  int ack_mode = 0, full_mode = 0;
  string tag = "R1";
  bit armed = 0;

  // behavioural reference model
  int m_act [N], m_rem [N], m_done [N], old_act [N];
  int m_grant = -1, m_bc = 0, m_ptr = 0;

  always @(posedge clk) begin : model
    int g; bit fin; bit got;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_act[i] = 0; m_rem[i] = 0; m_done[i] = 0; end
      m_grant = -1; m_bc = 0; m_ptr = 0;
    end else begin
      for (int i = 0; i < N; i++) begin old_act[i] = m_act[i]; m_done[i] = 0; end
      g = m_grant;
      if (g >= 0) begin
        fin = 0;
        if (ack) begin
          m_rem[g]--; m_bc++;
          if (m_rem[g] == 0) begin fin = 1; m_done[g] = 1; m_act[g] = 0; end
        end
        if (fin || m_bc == MB || full[g]) begin
          m_grant = -1; m_bc = 0; m_ptr = (g + 1) % N;
        end
      end else begin
        got = 0;
        for (int k = 0; k < N; k++) begin
          int p; p = (m_ptr + k) % N;
          if (!got && old_act[p] != 0 && !full[p]) begin got = 1; m_grant = p; end
        end
      end
      for (int i = 0; i < N; i++)
        if (start[i] && old_act[i] == 0 && len[i*CW +: CW] != 0) begin
          m_act[i] = 1; m_rem[i] = int'(len[i*CW +: CW]);
        end
    end
    armed = 1;
  end

  task automatic chk(string sig, string rq, logic [63:0] a, logic [63:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s [%s, phase %s] t=%0t: actual %h expected %h", sig, rq, tag, $time, a, e);
    end
  endtask

  always @(negedge clk) begin : compare
    logic [63:0] eg, ed, ea, er;
    if (armed) begin
      eg = '0; ed = '0; ea = '0; er = '0;
      for (int i = 0; i < N; i++) begin
        if (m_grant == i) eg[i] = 1'b1;
        ed[i] = (m_done[i] != 0);
        ea[i] = (m_act[i] != 0);
        er = er | (64'(m_rem[i]) << (i*CW));
      end
      chk("grant",     "R7",  64'(grant), eg);
      chk("bus_req",   "R10", 64'(bus_req), 64'(m_grant >= 0));
      chk("done",      "R8",  64'(done), ed);
      chk("active",    "R2",  64'(active), ea);
      chk("remaining", "R3",  64'(remaining), er);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      ack = (ack_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
      for (int i = 0; i < N; i++) full[i] = (full_mode != 0) && ($urandom % 6 == 0);
    end
  endtask

  task automatic arm(int c, int l);
    start[c] = 1'b1;
    len[c*CW +: CW] = CW'(l);
  endtask

  task automatic go();
    cyc(1);
    start = '0;
  endtask

  task automatic wait_idle(int limit);
    int t; bit busy;
    t = 0;
    do begin
      cyc(1); t++;
      busy = (m_grant >= 0);
      for (int i = 0; i < N; i++) if (m_act[i] != 0) busy = 1;
    end while (busy && t < limit);
    n_cmp++;
    if (busy) begin
      n_bad++;
      $display("FAIL drain [R8, phase %s]: actual busy expected idle after %0d cycles", tag, limit);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog [R8]: actual running expected finished");
    summary();
  end

  initial begin
    cyc(3);
    // R1: reset state observed at the ports
    n_cmp++;
    if (grant !== '0 || bus_req !== 1'b0 || done !== '0 || active !== '0 || remaining !== '0) begin
      n_bad++;
      $display("FAIL reset [R1]: actual %b/%b/%b/%b expected all zero", grant, bus_req, done, active);
    end
    rst = 1'b0;
    tag = "R1";  arm(0, 3); arm(1, 3); go(); wait_idle(200);
    tag = "R4";  arm(0, 10); go(); wait_idle(200);          // bursts 4,4,2; re-grant of lone channel
    tag = "R6";  arm(2, 9); arm(0, 6); arm(1, 5); go(); wait_idle(300);
    tag = "R3";  ack_mode = 1; arm(0, 13); arm(2, 7); go(); wait_idle(500);
    tag = "R5";  ack_mode = 0; full_mode = 1;
    arm(0, 12); arm(1, 12); arm(2, 12); go(); wait_idle(1000);
    tag = "R9";  ack_mode = 1; arm(1, 17); arm(2, 9); go(); wait_idle(1000);
    tag = "R2";  ack_mode = 0; full_mode = 0;
    arm(1, 20); go(); cyc(3);
    arm(1, 3); arm(0, 0); go();                            // both must be ignored
    cyc(2); wait_idle(300);
    tag = "R8";  arm(0, 1); arm(1, 1); arm(2, 1); go(); wait_idle(100);
    tag = "R2";  arm(2, 1 << XW); go(); wait_idle(20000);  // longest transfer
    tag = "R7";  arm(1, 2); go(); cyc(1); arm(0, 2); go(); wait_idle(100);
    cyc(2);
    summary();
  end
endmodule